// File: doc/BRIEF.md
# Streaming 5x5 Edge Magnitude Filter

This block takes a raster stream of 18-bit colour pixels, one per clock while `en` is high, and returns one edge-strength pixel per enabled clock. Each incoming pixel is reduced to a 6-bit grey level and shifted into a tapped history long enough to expose a 5x5 neighbourhood spanning five image lines of `LINE_W` pixels each. Two fixed 5x5 gradient kernels, one responding to horizontal change and one to vertical change, are applied to that neighbourhood. The absolute values of the two responses are summed, divided by 32 and limited to 63. That 6-bit strength is written to all three colour fields of a registered output pixel.

The stream is paused by dropping `en` during blanking, and every stage holds its contents while `en` is low. A small fill controller with two states tracks whether the history has seen enough pixels to hold a complete neighbourhood. After reset it sits in `FILL`, counting pushes. The transition `FILL -> STREAM` is taken on the enabled push that completes the neighbourhood. The controller leaves `STREAM` only through reset. A qualifying flag tracks each result down the pipeline and appears on `out_valid`.

Top module: `sobel_edge_stream`

## Requirements
- R1: Pixel layout is three 6-bit unsigned fields, with red in bits 17:12, green in bits 11:6 and blue in bits 5:0. The grey level is floor((red+green+blue)/3), exact for every channel sum from 0 to 189.
- R2: After n enabled pushes, neighbourhood element (row r, column c), with r and c in 0..4, holds the grey level pushed (4-r)*LINE_W+(4-c) pushes earlier. A position before the first push since reset reads as 0.
- R3: The horizontal kernel weight is a(r)*b(c) and the vertical kernel weight is b(r)*a(c), with a = {1,4,6,4,1} and b = {1,2,0,-2,-1} over indices 0..4. Both responses are formed as signed sums.
- R4: The strength is min(63, (|Gx|+|Gy|) >> 5).
- R5: The output pixel carries the strength in all three 6-bit fields.
- R6: The result for the neighbourhood that ends at push k appears on `pix_out` after the (k+3)-th enabled clock edge.
- R7: While `en` is low, `pix_out`, `out_valid` and the neighbourhood contents do not change.
- R8: `out_valid` is high after enabled edge e exactly when e-3 >= 4*LINE_W+5. Once high, it stays high until reset.
- R9: Synchronous active-high `rst` clears `pix_out`, `out_valid`, the pixel history and the fill count, and returns the controller to `FILL`.
- R10: The controller moves from `FILL` to `STREAM` on the enabled push that brings the count to 4*LINE_W+5. `out_valid` is never high while the controller is in `FILL`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Advances the history and pipeline when high |
| pix_in | input | 18 | Input pixel {red, green, blue} |
| pix_out | output | 18 | Registered strength, replicated in three fields |
| out_valid | output | 1 | Output belongs to a fully populated neighbourhood |

## Verification
The hardest condition to reach is saturation together with exact grey rounding while the neighbourhood spans line boundaries and `en` pauses. In those cycles the neighbourhood must not shift, even though the pipeline holds partial results. The stimulus uses a small line length. It first walks every channel sum from 0 to 189, then drives bright vertical bars and a horizontal stripe field to push both responses past the clamp. Enable gaps are inserted on a fixed cadence, and a mid-stream reset confirms that the history restarts from zero.

// File: rtl/sobel_pkg.sv
package sobel_pkg;
    localparam int CH_W     = 6;
    localparam int PIX_W    = 3 * CH_W;
    localparam int KSIZE    = 5;
    localparam int ACC_W    = 16;
    localparam int MAG_SHIFT = 5;
    localparam int MAG_MAX  = 63;

    typedef enum logic {
        ST_FILL   = 1'b0,
        ST_STREAM = 1'b1
    } fill_state_e;

    function automatic int smooth_w(input int i);
        case (i)
            0, 4:    return 1;
            1, 3:    return 4;
            default: return 6;
        endcase
    endfunction

    function automatic int diff_w(input int i);
        case (i)
            0:       return 1;
            1:       return 2;
            3:       return -2;
            4:       return -1;
            default: return 0;
        endcase
    endfunction
endpackage

// File: rtl/sobel_grey.sv
module sobel_grey
    import sobel_pkg::*;
(
    input  logic [PIX_W-1:0] pix,
    output logic [CH_W-1:0]  grey
);
    logic [7:0] chan_sum;

    assign chan_sum = 8'(pix[3*CH_W-1:2*CH_W]) + 8'(pix[2*CH_W-1:CH_W]) + 8'(pix[CH_W-1:0]);
    // multiply by 171/512: floor result equals floor(sum/3) for sums up to 189
    assign grey = CH_W'((16'(chan_sum) * 16'd171) >> 9);
endmodule

// File: rtl/sobel_window.sv
module sobel_window
    import sobel_pkg::*;
#(
    parameter int TAPS = 37
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       en,
    input  logic [CH_W-1:0]            din,
    output logic [TAPS-1:0][CH_W-1:0]  hist
);
    always_ff @(posedge clk) begin
        if (rst) begin
            hist <= '0;
        end else if (en) begin
            hist <= {hist[TAPS-2:0], din};
        end
    end
endmodule

// File: rtl/sobel_conv.sv
module sobel_conv
    import sobel_pkg::*;
(
    input  logic [KSIZE-1:0][KSIZE-1:0][CH_W-1:0] win,
    output logic signed [ACC_W-1:0]              gx,
    output logic signed [ACC_W-1:0]              gy
);
    int acc_x;
    int acc_y;

    always_comb begin
        acc_x = 0;
        acc_y = 0;
        for (int r = 0; r < KSIZE; r++) begin
            for (int c = 0; c < KSIZE; c++) begin
                acc_x = acc_x + int'(win[r][c]) * (smooth_w(r) * diff_w(c));
                acc_y = acc_y + int'(win[r][c]) * (diff_w(r) * smooth_w(c));
            end
        end
    end

    assign gx = ACC_W'(acc_x);
    assign gy = ACC_W'(acc_y);
endmodule

// File: rtl/sobel_edge_stream.sv
module sobel_edge_stream
    import sobel_pkg::*;
#(
    parameter int LINE_W = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [17:0]      pix_in,
    output logic [17:0]      pix_out,
    output logic             out_valid
);
    localparam int TAPS  = (KSIZE - 1) * LINE_W + KSIZE;
    localparam int CNT_W = $clog2(TAPS + 1);

    logic [CH_W-1:0]                       grey;
    logic [TAPS-1:0][CH_W-1:0]             hist;
    logic [KSIZE-1:0][KSIZE-1:0][CH_W-1:0] win;
    logic signed [ACC_W-1:0]               gx, gy;
    logic signed [ACC_W-1:0]               gx_q, gy_q;
    logic [ACC_W-1:0]                      abs_x, abs_y;
    logic [ACC_W:0]                        mag_sum;
    logic [ACC_W-MAG_SHIFT:0]              scaled;
    logic [CH_W-1:0]                       mag, mag_q;
    logic                                  v_conv, v_mag;
    fill_state_e                           state_q, state_d;
    logic [CNT_W-1:0]                      fill_cnt;
    logic                                  streaming;

    sobel_grey u_grey (.pix(pix_in), .grey(grey));

    sobel_window #(.TAPS(TAPS)) u_win (
        .clk(clk), .rst(rst), .en(en), .din(grey), .hist(hist)
    );

    for (genvar r = 0; r < KSIZE; r++) begin : g_row
        for (genvar c = 0; c < KSIZE; c++) begin : g_col
            assign win[r][c] = hist[(KSIZE-1-r)*LINE_W + (KSIZE-1-c)];
        end
    end

    sobel_conv u_conv (.win(win), .gx(gx), .gy(gy));

    // fill controller: next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_FILL:   if (en && fill_cnt == CNT_W'(TAPS - 1)) state_d = ST_STREAM;
            ST_STREAM: state_d = ST_STREAM;
        endcase
    end

    // fill controller: state register and push count
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_FILL;
            fill_cnt <= '0;
        end else begin
            state_q <= state_d;
            if (en && state_q == ST_FILL) fill_cnt <= fill_cnt + 1'b1;
        end
    end

    assign streaming = (state_q == ST_STREAM);

    assign abs_x   = gx_q[ACC_W-1] ? ACC_W'(-gx_q) : ACC_W'(gx_q);
    assign abs_y   = gy_q[ACC_W-1] ? ACC_W'(-gy_q) : ACC_W'(gy_q);
    assign mag_sum = {1'b0, abs_x} + {1'b0, abs_y};
    assign scaled  = (ACC_W-MAG_SHIFT+1)'(mag_sum >> MAG_SHIFT);
    assign mag     = (scaled > (ACC_W-MAG_SHIFT+1)'(MAG_MAX)) ? CH_W'(MAG_MAX) : scaled[CH_W-1:0];

    // datapath and output registers
    always_ff @(posedge clk) begin
        if (rst) begin
            gx_q      <= '0;
            gy_q      <= '0;
            v_conv    <= 1'b0;
            mag_q     <= '0;
            v_mag     <= 1'b0;
            pix_out   <= '0;
            out_valid <= 1'b0;
        end else if (en) begin
            gx_q      <= gx;
            gy_q      <= gy;
            v_conv    <= streaming;
            mag_q     <= mag;
            v_mag     <= v_conv;
            pix_out   <= {mag_q, mag_q, mag_q};
            out_valid <= v_mag;
        end
    end
endmodule

// File: rtl/sobel_edge_chk.sv
module sobel_edge_chk (
    input logic        clk,
    input logic        rst,
    input logic        en,
    input logic [17:0] pix_out,
    input logic        out_valid,
    input logic        streaming
);
    // R9
    reset_clears_chk: assert property (@(posedge clk)
        rst |=> (pix_out == 18'd0 && !out_valid && !streaming));

    // R7
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !en |=> ($stable(pix_out) && $stable(out_valid)));

    // R8
    valid_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> out_valid);

    // R10
    valid_needs_stream_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> streaming);

    // R10
    stream_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        streaming |=> streaming);

    // R5
    fields_match_chk: assert property (@(posedge clk) disable iff (rst)
        (pix_out[17:12] == pix_out[11:6]) && (pix_out[11:6] == pix_out[5:0]));
endmodule

bind sobel_edge_stream sobel_edge_chk u_chk (
    .clk(clk), .rst(rst), .en(en), .pix_out(pix_out),
    .out_valid(out_valid), .streaming(streaming)
);

// File: tb/sobel_edge_stream_tb.sv
module sobel_edge_stream_tb;
    localparam int L    = 8;
    localparam int TAPS = 4 * L + 5;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        en  = 1'b0;
    logic [17:0] pix_in = '0;
    logic [17:0] pix_out;
    logic        out_valid;

    int checks = 0;
    int errors = 0;
    int e = 0;
    int base = 0;
    int cyc = 0;
    int gmem [0:8191];

    int A [5] = '{1, 4, 6, 4, 1};
    int B [5] = '{1, 2, 0, -2, -1};

    always #2.5 clk = ~clk;

    sobel_edge_stream #(.LINE_W(L)) u_dut (
        .clk(clk), .rst(rst), .en(en), .pix_in(pix_in),
        .pix_out(pix_out), .out_valid(out_valid)
    );

    task automatic report();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run hung, actual %0d cycles expected < 150000", cyc);
            report();
        end
    end

    // R2: samples before the first push since reset read as zero
    function automatic int pix_at(int k);
        return (k >= 1) ? gmem[base + k] : 0;
    endfunction

    // R3 R4: model of the strength for the neighbourhood ending at push k
    function automatic int model_mag(int k);
        int gx = 0, gy = 0, v, s;
        for (int r = 0; r < 5; r++)
            for (int c = 0; c < 5; c++) begin
                v = pix_at(k - ((4 - r) * L + (4 - c)));
                gx += A[r] * B[c] * v;
                gy += B[r] * A[c] * v;
            end
        if (gx < 0) gx = -gx;
        if (gy < 0) gy = -gy;
        s = (gx + gy) >>> 5;
        return (s > 63) ? 63 : s;
    endfunction

    task automatic check_out();
        int k = e - 3;
        int m = model_mag(k);
        logic [17:0] exp_pix = {m[5:0], m[5:0], m[5:0]};
        logic exp_v = (k >= TAPS);
        checks++;
        if (pix_out !== exp_pix) begin
            errors++;
            $display("FAIL R1/R2/R3/R4/R5/R6: edge %0d pix_out actual %h expected %h", e, pix_out, exp_pix);
        end
        checks++;
        if (out_valid !== exp_v) begin
            errors++;
            $display("FAIL R8: edge %0d out_valid actual %b expected %b", e, out_valid, exp_v);
        end
    endtask

    // one cycle: drive at negedge, check at next negedge (R6 R7)
    task automatic step(input logic e_in, input logic [17:0] p);
        en = e_in;
        pix_in = p;
        if (e_in) gmem[base + e + 1] = (int'(p[17:12]) + int'(p[11:6]) + int'(p[5:0])) / 3;
        @(posedge clk);
        if (e_in) e++;
        @(negedge clk);
        check_out();
    endtask

    function automatic logic [17:0] sum_pix(int s);
        int r = (s > 63) ? 63 : s;
        int g = ((s - r) > 63) ? 63 : (s - r);
        int b = s - r - g;
        return {r[5:0], g[5:0], b[5:0]};
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        // R9: reset state
        checks++;
        if (pix_out !== 18'd0 || out_valid !== 1'b0) begin
            errors++;
            $display("FAIL R9: reset actual %h/%b expected 0/0", pix_out, out_valid);
        end
        rst = 1'b0;

        // R1: every channel sum 0..189, twice, with enable gaps (R7)
        for (int i = 0; i < 380; i++) step((i % 7) != 6, sum_pix(i % 190));

        // R4: bright vertical bars to saturate the horizontal response
        for (int i = 0; i < 400; i++) step((i % 5) != 4, ((i % L) < 3) ? 18'h3FFFF : 18'h0);

        // R3: horizontal stripe field drives the vertical response
        for (int i = 0; i < 400; i++) step(1'b1, (((i / L) % 3) == 0) ? 18'h3FFFF : {6'd5, 6'd9, 6'd20});

        // mixed pattern, long pause (R7)
        for (int i = 0; i < 300; i++) step(1'b1, {6'((i * 7 + 3) % 64), 6'((i * 13) % 64), 6'((i * 29 + 11) % 64)});
        for (int i = 0; i < 20; i++) step(1'b0, 18'h3FFFF);

        // R9 R10: mid-stream reset restarts fill and clears history
        @(negedge clk);
        rst = 1'b1;
        en = 1'b1;
        repeat (2) @(negedge clk);
        checks++;
        if (pix_out !== 18'd0 || out_valid !== 1'b0) begin
            errors++;
            $display("FAIL R9: mid reset actual %h/%b expected 0/0", pix_out, out_valid);
        end
        rst = 1'b0;
        base = base + e + 16;
        e = 0;
        for (int i = 0; i < 200; i++) step((i % 3) != 2, ((i % L) == 4) ? 18'h3FFC0 : 18'h00FC0);

        report();
    end
endmodule